// File: doc/BRIEF.md
# SDRAM Bank State and Timing Tracker

This block sits on the command bus of a single-rank, four-bank SDRAM and follows every command the controller issues. It decodes the command from the chip-select, row-strobe, column-strobe and write-enable pins, the bank address and address bit 10. It keeps, for each bank, whether the bank is idle, holds an open row or is precharging, together with the timers that decide when the next command to that bank may follow. For every command it gives a verdict one cycle later: legal, or illegal with a code naming the rule that was broken.

An illegal command is reported and otherwise ignored: the bank state stays as it was, and a sticky flag latches the code of the first violation seen since reset. The block also publishes which banks hold an open row, the row each one holds, and whether all banks are idle, which a refresh scheduler uses. Minimum spacings (row-to-column delay, same-bank activate cycle, cross-bank activate spacing, minimum row-active time and precharge time) are parameters in clock cycles. The burst length is a parameter as well, and sets when a read burst ends and when an auto-precharge starts.

Top module: `sdram_bank_tracker`

## Requirements
- R1: The command is decoded from {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-register load (either register), 0110 burst terminate. 0111 (no operation) and any pattern with cs_n high give no verdict and change nothing. Every other command gives verdict_valid high for exactly one cycle after the edge that samples it.
- R2: A read or write is legal only if the addressed bank holds an open row and at least T_RCD cycles have passed since its activate. Otherwise the code is 1 (bank not open) or 2 (too early).
- R3: An activate is legal only if the bank is idle or has finished precharging (else code 3). It also needs at least T_RC cycles since the last activate to the same bank (else code 4) and at least T_RRD cycles since the last activate to any bank (else code 5). Code 3 takes priority over 4, and 4 over 5.
- R4: For a precharge, address bit 10 high selects all banks and low selects the bank on ba. A selected open bank becomes idle in the cycle in which T_RP cycles have passed since the precharge and T_RAS cycles have passed since its activate. all_idle rises after the edge of that cycle.
- R5: A precharge to a bank that is idle, already precharging or waiting for its auto-precharge is legal and does not change that bank's state or timers.
- R6: A read or write with address bit 10 high schedules an auto-precharge. The bank stops reporting an open row BURST_LEN/2 cycles after the command and then follows the R4 timing from that point. Until then a read or write to that bank gives code 9.
- R7: Refresh and mode-register load are legal only when every bank is idle or has finished precharging (else code 6).
- R8: A read keeps a read burst in progress for the BURST_LEN/2-1 cycles that follow it. A burst terminate is legal only while a burst from a read without auto-precharge is in progress, and it ends that burst (else code 7). A write during a burst in progress gives code 8.
- R9: An illegal command changes no bank state, row or timer. err_sticky rises with the first illegal command and stays high until reset, and err_first_code keeps the code of that first command.
- R10: After reset no bank is open, all_idle is high, err_sticky is low and no verdict is pending. bank_row carries the row of each open bank at bits [b*ADDR_W +: ADDR_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (12) | Address; row on activate, bit 10 selects all-bank or auto-precharge |
| verdict_valid | output | 1 | A command was judged in the previous cycle |
| verdict_ok | output | 1 | That command was legal |
| verdict_code | output | 4 | Rule code of that command, 0 when legal |
| err_sticky | output | 1 | An illegal command has been seen since reset |
| err_first_code | output | 4 | Code of the first illegal command |
| bank_open | output | NUM_BANKS (4) | One bit per bank holding an open row |
| bank_row | output | NUM_BANKS*ADDR_W (48) | Open row of each bank |
| all_idle | output | 1 | Every bank is idle |

## Verification
The bench drives each command on a falling edge and reads the results on the next falling edge. The verdict, the code, the sticky flag, bank_open and bank_row are all due after that single rising edge. all_idle is due one edge after the cycle in which the precharge and row-active times are both met. An auto-precharge drops bank_open at the edge BURST_LEN/2 cycles after the read or write. Spacing rules are swept over every command gap in a small window around each threshold, including every precharge-then-reactivate pair. The expected verdict at each gap is computed arithmetically from the cycle count, so each check lands on the exact sample where the result first becomes due.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_LMR, CMD_BST
  } sdt_cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_OPEN, BK_PRECH
  } sdt_bank_e;

  typedef enum logic [3:0] {
    ERR_NONE        = 4'd0,
    ERR_NOT_OPEN    = 4'd1,
    ERR_TRCD        = 4'd2,
    ERR_BANK_BUSY   = 4'd3,
    ERR_TRC         = 4'd4,
    ERR_TRRD        = 4'd5,
    ERR_NOT_IDLE    = 4'd6,
    ERR_NO_BURST    = 4'd7,
    ERR_RD_INFLIGHT = 4'd8,
    ERR_AP_PENDING  = 4'd9
  } sdt_err_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
  import sdt_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdt_cmd_e cmd
);

  always_comb begin
    unique case ({cs_n, ras_n, cas_n, we_n})
      4'b0011: cmd = CMD_ACT;
      4'b0101: cmd = CMD_RD;
      4'b0100: cmd = CMD_WR;
      4'b0010: cmd = CMD_PRE;
      4'b0001: cmd = CMD_REF;
      4'b0000: cmd = CMD_LMR;
      4'b0110: cmd = CMD_BST;
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdt_bank.sv
module sdt_bank
  import sdt_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int CW        = 4,
  parameter int T_RAS     = 4,
  parameter int T_RP      = 2,
  parameter int BURST_CYC = 4,
  parameter int BCW       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_act,
  input  logic             do_rdwr,
  input  logic             ap_req,
  input  logic             do_pre,
  input  logic [ROW_W-1:0] row_in,
  output sdt_bank_e        state_o,
  output logic [ROW_W-1:0] row_o,
  output logic [CW-1:0]    act_age_o,
  output logic             ready_o,
  output logic             ap_busy_o
);

  localparam logic [CW-1:0]  AGE_MAX = '1;
  localparam logic [CW-1:0]  AGE_ONE = CW'(1);
  localparam logic [CW-1:0]  RAS_C   = CW'(T_RAS);
  localparam logic [CW-1:0]  RP_C    = CW'(T_RP);
  localparam logic [BCW-1:0] BC_C    = BCW'(BURST_CYC);
  localparam logic [BCW-1:0] BC_ONE  = BCW'(1);

  sdt_bank_e        state_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    act_age_q;
  logic [CW-1:0]    pre_age_q;
  logic             ap_q;
  logic [BCW-1:0]   ap_left_q;

  assign ready_o = (state_q == BK_IDLE) ||
                   ((state_q == BK_PRECH) && (pre_age_q >= RP_C) && (act_age_q >= RAS_C));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BK_IDLE;
      row_q     <= '0;
      act_age_q <= AGE_MAX;
      pre_age_q <= AGE_MAX;
      ap_q      <= 1'b0;
      ap_left_q <= '0;
    end else begin
      if (act_age_q != AGE_MAX) act_age_q <= act_age_q + AGE_ONE;
      if (pre_age_q != AGE_MAX) pre_age_q <= pre_age_q + AGE_ONE;
      if (do_act) begin
        state_q   <= BK_OPEN;
        row_q     <= row_in;
        act_age_q <= AGE_ONE;
        ap_q      <= 1'b0;
      end else if (ap_q) begin
        ap_left_q <= ap_left_q - BC_ONE;
        if (ap_left_q == BC_ONE) begin
          state_q   <= BK_PRECH;
          pre_age_q <= AGE_ONE;
          ap_q      <= 1'b0;
        end
      end else if (do_rdwr && ap_req) begin
        ap_q      <= 1'b1;
        ap_left_q <= BC_C;
      end else if (do_pre) begin
        state_q   <= BK_PRECH;
        pre_age_q <= AGE_ONE;
      end else if ((state_q == BK_PRECH) && ready_o) begin
        state_q <= BK_IDLE;
      end
    end
  end

  assign state_o   = state_q;
  assign row_o     = row_q;
  assign act_age_o = act_age_q;
  assign ap_busy_o = ap_q;

  AST_RDWR_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
    do_rdwr |-> (state_q == BK_OPEN) && !ap_q); // R2

  AST_ACT_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    do_act |-> ready_o); // R3

  AST_IDLE_AFTER_TIMES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (state_q == BK_IDLE) && ($past(state_q) == BK_PRECH))
      |-> (($past(pre_age_q) >= RP_C) && ($past(act_age_q) >= RAS_C))); // R4

  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (ap_q && (ap_left_q == BC_ONE)) |=> (state_q == BK_PRECH)); // R6

endmodule

// File: rtl/sdt_read_burst.sv
module sdt_read_burst #(
  parameter int BURST_CYC = 4,
  parameter int BCW       = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  input  logic rd_ap,
  input  logic bst_go,
  output logic rd_busy,
  output logic bst_ok
);

  localparam logic [BCW-1:0] TAIL_C = BCW'(BURST_CYC - 1);
  localparam logic [BCW-1:0] ONE_C  = BCW'(1);

  logic [BCW-1:0] left_q;
  logic           ap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      ap_q   <= 1'b0;
    end else if (rd_go) begin
      left_q <= TAIL_C;
      ap_q   <= rd_ap;
    end else if (bst_go) begin
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - ONE_C;
    end
  end

  assign rd_busy = (left_q != '0);
  assign bst_ok  = rd_busy && !ap_q;

  AST_BST_HAS_TARGET: assert property (@(posedge clk) disable iff (rst)
    bst_go |-> (left_q != '0) && !ap_q); // R8

  AST_BST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (bst_go && !rd_go) |=> !rd_busy); // R8

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 2,
  parameter int T_RC      = 6,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 4,
  parameter int T_RP      = 2,
  parameter int BURST_LEN = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [$clog2(NUM_BANKS)-1:0]  ba,
  input  logic [ADDR_W-1:0]             addr,
  output logic                          verdict_valid,
  output logic                          verdict_ok,
  output logic [3:0]                    verdict_code,
  output logic                          err_sticky,
  output logic [3:0]                    err_first_code,
  output logic [NUM_BANKS-1:0]          bank_open,
  output logic [NUM_BANKS*ADDR_W-1:0]   bank_row,
  output logic                          all_idle
);

  localparam int BA_W      = $clog2(NUM_BANKS);
  localparam int BURST_CYC = (BURST_LEN / 2 < 1) ? 1 : BURST_LEN / 2;
  localparam int BCW       = $clog2(BURST_CYC + 1);
  localparam int TMAX      = max2(max2(max2(T_RCD, T_RC), max2(T_RRD, T_RAS)), T_RP);
  localparam int CW        = $clog2(TMAX + 2);
  localparam logic [CW-1:0] AGE_MAX = '1;
  localparam logic [CW-1:0] AGE_ONE = CW'(1);
  localparam logic [CW-1:0] RCD_C   = CW'(T_RCD);
  localparam logic [CW-1:0] RC_C    = CW'(T_RC);
  localparam logic [CW-1:0] RRD_C   = CW'(T_RRD);

  sdt_cmd_e cmd;
  sdt_err_e err;
  logic     legal;

  sdt_bank_e            bk_state   [NUM_BANKS];
  logic [ADDR_W-1:0]    bk_row     [NUM_BANKS];
  logic [CW-1:0]        bk_act_age [NUM_BANKS];
  logic [NUM_BANKS-1:0] bk_ready;
  logic [NUM_BANKS-1:0] bk_ap;
  logic [NUM_BANKS-1:0] act_go, rdwr_go, pre_go;

  logic [CW-1:0] gact_q;
  logic          rd_busy, bst_ok;

  sdt_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdt_read_burst #(
    .BURST_CYC (BURST_CYC),
    .BCW       (BCW)
  ) u_burst (
    .clk     (clk),
    .rst     (rst),
    .rd_go   ((cmd == CMD_RD) && legal),
    .rd_ap   (addr[AP_BIT]),
    .bst_go  ((cmd == CMD_BST) && legal),
    .rd_busy (rd_busy),
    .bst_ok  (bst_ok)
  );

  // Rule evaluation: earlier tests take priority.
  always_comb begin
    err = ERR_NONE;
    unique case (cmd)
      CMD_ACT: begin
        if (!bk_ready[ba])                err = ERR_BANK_BUSY;
        else if (bk_act_age[ba] < RC_C)   err = ERR_TRC;
        else if (gact_q < RRD_C)          err = ERR_TRRD;
      end
      CMD_RD, CMD_WR: begin
        if ((cmd == CMD_WR) && rd_busy)   err = ERR_RD_INFLIGHT;
        else if (bk_state[ba] != BK_OPEN) err = ERR_NOT_OPEN;
        else if (bk_ap[ba])               err = ERR_AP_PENDING;
        else if (bk_act_age[ba] < RCD_C)  err = ERR_TRCD;
      end
      CMD_REF, CMD_LMR: begin
        if (!(&bk_ready))                 err = ERR_NOT_IDLE;
      end
      CMD_BST: begin
        if (!bst_ok)                      err = ERR_NO_BURST;
      end
      default: err = ERR_NONE;
    endcase
  end

  assign legal = (err == ERR_NONE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BA_W-1:0] BIDX = BA_W'(b);

    assign act_go[b]  = (cmd == CMD_ACT) && legal && (ba == BIDX);
    assign rdwr_go[b] = ((cmd == CMD_RD) || (cmd == CMD_WR)) && legal && (ba == BIDX);
    assign pre_go[b]  = (cmd == CMD_PRE) && (addr[AP_BIT] || (ba == BIDX)) &&
                        (bk_state[b] == BK_OPEN) && !bk_ap[b];

    sdt_bank #(
      .ROW_W     (ADDR_W),
      .CW        (CW),
      .T_RAS     (T_RAS),
      .T_RP      (T_RP),
      .BURST_CYC (BURST_CYC),
      .BCW       (BCW)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .do_act    (act_go[b]),
      .do_rdwr   (rdwr_go[b]),
      .ap_req    (addr[AP_BIT]),
      .do_pre    (pre_go[b]),
      .row_in    (addr),
      .state_o   (bk_state[b]),
      .row_o     (bk_row[b]),
      .act_age_o (bk_act_age[b]),
      .ready_o   (bk_ready[b]),
      .ap_busy_o (bk_ap[b])
    );

    assign bank_open[b]                   = (bk_state[b] == BK_OPEN);
    assign bank_row[b*ADDR_W +: ADDR_W]   = bk_row[b];
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bk_state[b] != BK_IDLE) all_idle = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gact_q         <= AGE_MAX;
      verdict_valid  <= 1'b0;
      verdict_ok     <= 1'b0;
      verdict_code   <= ERR_NONE;
      err_sticky     <= 1'b0;
      err_first_code <= ERR_NONE;
    end else begin
      if (|act_go)                gact_q <= AGE_ONE;
      else if (gact_q != AGE_MAX) gact_q <= gact_q + AGE_ONE;
      verdict_valid <= (cmd != CMD_NOP);
      verdict_ok    <= (cmd != CMD_NOP) && legal;
      verdict_code  <= (cmd != CMD_NOP) ? err : ERR_NONE;
      if ((cmd != CMD_NOP) && !legal && !err_sticky) begin
        err_sticky     <= 1'b1;
        err_first_code <= err;
      end
    end
  end

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky); // R9

  AST_FIRST_CODE_KEPT: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> $stable(err_first_code)); // R9

  AST_RRD_SPACING: assert property (@(posedge clk) disable iff (rst)
    (|act_go) |-> (gact_q >= RRD_C)); // R3

  AST_REF_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    (((cmd == CMD_REF) || (cmd == CMD_LMR)) && legal) |=> all_idle); // R7

  AST_ONE_ACT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_go)); // R3

endmodule

// File: tb/sdram_bank_tracker_test.sv
module sdram_bank_tracker_test;

  localparam int NB = 4;
  localparam int AW = 12;
  localparam int T_RCD = 2, T_RC = 6, T_RRD = 2, T_RAS = 4, T_RP = 2;
  localparam int BL = 8;

  localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000,
                         P_BST = 4'b0110, P_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic verdict_valid, verdict_ok, err_sticky, all_idle;
  logic [3:0] verdict_code, err_first_code;
  logic [NB-1:0] bank_open;
  logic [NB*AW-1:0] bank_row;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_bank_tracker #(
    .NUM_BANKS(NB), .ADDR_W(AW), .AP_BIT(10), .T_RCD(T_RCD), .T_RC(T_RC),
    .T_RRD(T_RRD), .T_RAS(T_RAS), .T_RP(T_RP), .BURST_LEN(BL)
  ) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .verdict_valid(verdict_valid), .verdict_ok(verdict_ok),
    .verdict_code(verdict_code), .err_sticky(err_sticky),
    .err_first_code(err_first_code), .bank_open(bank_open), .bank_row(bank_row),
    .all_idle(all_idle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic verdict(input string tag, input logic ok, input logic [3:0] code);
    chk({tag, " valid"}, {31'd0, verdict_valid}, 32'd1);
    chk({tag, " ok"},    {31'd0, verdict_ok},    {31'd0, ok});
    chk({tag, " code"},  {28'd0, verdict_code},  {28'd0, code});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one command at a falling edge; return at the next falling edge.
  task automatic send(input logic [3:0] pins, input int b, input logic a10,
                      input logic [AW-1:0] row);
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = b[1:0];
    addr = row;
    if (pins != P_ACT) addr[10] = a10;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R10 reset state
    chk("R10 reset valid", {31'd0, verdict_valid}, 32'd0);
    chk("R10 reset open", {28'd0, bank_open}, 32'd0);
    chk("R10 reset idle", {31'd0, all_idle}, 32'd1);
    chk("R10 reset sticky", {31'd0, err_sticky}, 32'd0);

    // R1 no-operation and deselect give no verdict, change nothing
    send(P_NOP, 0, 1'b0, '0);
    chk("R1 nop valid", {31'd0, verdict_valid}, 32'd0);
    send(4'b1011, 1, 1'b0, 12'h123);
    chk("R1 deselect valid", {31'd0, verdict_valid}, 32'd0);
    chk("R1 deselect open", {28'd0, bank_open}, 32'd0);
    send(P_REF, 0, 1'b0, '0);
    verdict("R1 ref decoded", 1'b1, 4'd0);
    idle(1);
    chk("R1 verdict one cycle", {31'd0, verdict_valid}, 32'd0);

    // R2 row-to-column sweep, read and write
    for (int op = 0; op < 2; op++) begin
      for (int d = 1; d <= 4; d++) begin
        do_reset();
        send(P_ACT, 1, 1'b0, 12'h5A3);
        if (d == 1) begin
          chk("R10 row", {20'd0, bank_row[AW +: AW]}, 32'h5A3);
          chk("R10 open", {28'd0, bank_open}, 32'h2);
        end
        idle(d - 1);
        send(op == 0 ? P_RD : P_WR, 1, 1'b0, '0);
        verdict($sformatf("R2 op%0d gap%0d", op, d), d >= T_RCD, d >= T_RCD ? 4'd0 : 4'd2);
      end
    end
    send(P_RD, 2, 1'b0, '0);
    verdict("R2 read closed bank", 1'b0, 4'd1);

    // R3 cross-bank spacing sweep
    for (int d = 1; d <= 4; d++) begin
      do_reset();
      send(P_ACT, 0, 1'b0, 12'h010);
      idle(d - 1);
      send(P_ACT, 2, 1'b0, 12'h020);
      verdict($sformatf("R3 rrd gap%0d", d), d >= T_RRD, d >= T_RRD ? 4'd0 : 4'd5);
    end
    send(P_ACT, 0, 1'b0, 12'h030);
    verdict("R3 act open bank", 1'b0, 4'd3);

    // R3/R4 reopen after precharge: every precharge gap p and activate gap d
    for (int p = 1; p <= 4; p++) begin
      for (int d = p + 1; d <= 9; d++) begin
        logic rdy;
        logic [3:0] code;
        do_reset();
        send(P_ACT, 0, 1'b0, 12'h0AA);
        idle(p - 1);
        send(P_PRE, 0, 1'b0, '0);
        idle(d - p - 1);
        send(P_ACT, 0, 1'b0, 12'h0BB);
        rdy = ((d - p) >= T_RP) && (d >= T_RAS);
        code = !rdy ? 4'd3 : (d < T_RC) ? 4'd4 : 4'd0;
        verdict($sformatf("R3 R4 reopen p%0d d%0d", p, d), code == 4'd0, code);
      end
    end

    // R4 all-bank precharge and idle timing
    do_reset();
    send(P_ACT, 0, 1'b0, 12'h001);
    idle(1);
    send(P_ACT, 1, 1'b0, 12'h002);
    idle(5);
    send(P_PRE, 3, 1'b1, '0);
    verdict("R4 pre all", 1'b1, 4'd0);
    chk("R4 pre all closes", {28'd0, bank_open}, 32'd0);
    chk("R4 not idle yet", {31'd0, all_idle}, 32'd0);
    idle(1);
    chk("R4 idle early", {31'd0, all_idle}, 32'd0);
    idle(1);
    chk("R4 idle on time", {31'd0, all_idle}, 32'd1);
    // R4 single-bank precharge
    do_reset();
    send(P_ACT, 0, 1'b0, 12'h001);
    idle(1);
    send(P_ACT, 1, 1'b0, 12'h002);
    idle(1);
    send(P_PRE, 1, 1'b0, '0);
    chk("R4 single bank", {28'd0, bank_open}, 32'h1);

    // R5 precharge to idle or precharging bank is a legal no-op
    do_reset();
    send(P_PRE, 3, 1'b0, '0);
    verdict("R5 pre idle bank", 1'b1, 4'd0);
    chk("R5 idle kept", {31'd0, all_idle}, 32'd1);
    send(P_ACT, 0, 1'b0, 12'h044);
    idle(3);
    send(P_PRE, 0, 1'b0, '0);
    send(P_PRE, 0, 1'b0, '0);
    verdict("R5 pre precharging", 1'b1, 4'd0);
    chk("R5 not idle yet", {31'd0, all_idle}, 32'd0);
    idle(1);
    chk("R5 timer not restarted", {31'd0, all_idle}, 32'd1);

    // R6 auto-precharge after a read
    do_reset();
    send(P_ACT, 0, 1'b0, 12'h066);
    idle(1);
    send(P_RD, 0, 1'b1, '0);
    verdict("R6 read ap", 1'b1, 4'd0);
    send(P_RD, 0, 1'b0, '0);
    verdict("R6 read during ap", 1'b0, 4'd9);
    idle(2);
    chk("R6 open until burst end", {28'd0, bank_open}, 32'h1);
    idle(1);
    chk("R6 closed at burst end", {28'd0, bank_open}, 32'h0);
    send(P_ACT, 0, 1'b0, 12'h067);
    verdict("R6 act before trp", 1'b0, 4'd3);
    send(P_ACT, 0, 1'b0, 12'h068);
    verdict("R6 act after trp", 1'b1, 4'd0);
    // R6 auto-precharge after a write
    do_reset();
    send(P_ACT, 2, 1'b0, 12'h070);
    idle(1);
    send(P_WR, 2, 1'b1, '0);
    idle(3);
    chk("R6 wr open", {28'd0, bank_open}, 32'h4);
    idle(1);
    chk("R6 wr closed", {28'd0, bank_open}, 32'h0);
    idle(1);
    chk("R6 wr not idle", {31'd0, all_idle}, 32'd0);
    idle(1);
    chk("R6 wr idle", {31'd0, all_idle}, 32'd1);

    // R7 refresh and mode load need all banks idle
    do_reset();
    send(P_REF, 0, 1'b0, '0);
    verdict("R7 ref idle", 1'b1, 4'd0);
    send(P_ACT, 0, 1'b0, 12'h080);
    send(P_REF, 0, 1'b0, '0);
    verdict("R7 ref open", 1'b0, 4'd6);
    send(P_LMR, 1, 1'b0, '0);
    verdict("R7 lmr open", 1'b0, 4'd6);
    idle(1);
    send(P_PRE, 0, 1'b0, '0);
    idle(1);
    send(P_REF, 0, 1'b0, '0);
    verdict("R7 ref at trp", 1'b1, 4'd0);
    chk("R7 idle after ref", {31'd0, all_idle}, 32'd1);
    send(P_LMR, 0, 1'b0, '0);
    verdict("R7 lmr idle", 1'b1, 4'd0);

    // R8 burst terminate and write during read
    do_reset();
    send(P_ACT, 0, 1'b0, 12'h090);
    idle(1);
    send(P_RD, 0, 1'b0, '0);
    send(P_WR, 0, 1'b0, '0);
    verdict("R8 write during read", 1'b0, 4'd8);
    send(P_BST, 0, 1'b0, '0);
    verdict("R8 bst legal", 1'b1, 4'd0);
    send(P_WR, 0, 1'b0, '0);
    verdict("R8 write after bst", 1'b1, 4'd0);
    do_reset();
    send(P_ACT, 0, 1'b0, 12'h091);
    idle(1);
    send(P_RD, 0, 1'b0, '0);
    idle(2);
    send(P_WR, 0, 1'b0, '0);
    verdict("R8 write at burst tail", 1'b0, 4'd8);
    send(P_WR, 0, 1'b0, '0);
    verdict("R8 write after burst", 1'b1, 4'd0);
    send(P_BST, 0, 1'b0, '0);
    verdict("R8 bst no burst", 1'b0, 4'd7);
    do_reset();
    send(P_ACT, 1, 1'b0, 12'h092);
    idle(1);
    send(P_RD, 1, 1'b1, '0);
    send(P_BST, 1, 1'b0, '0);
    verdict("R8 bst on ap read", 1'b0, 4'd7);

    // R9 illegal commands leave state; sticky first code
    do_reset();
    send(P_ACT, 0, 1'b0, 12'h111);
    send(P_RD, 0, 1'b1, '0);
    verdict("R9 early ap read", 1'b0, 4'd2);
    chk("R9 sticky set", {31'd0, err_sticky}, 32'd1);
    chk("R9 first code", {28'd0, err_first_code}, 32'd2);
    send(P_ACT, 0, 1'b0, 12'h222);
    verdict("R9 act open", 1'b0, 4'd3);
    chk("R9 row kept", {20'd0, bank_row[0 +: AW]}, 32'h111);
    chk("R9 first kept", {28'd0, err_first_code}, 32'd2);
    idle(5);
    chk("R9 no ap started", {28'd0, bank_open}, 32'h1);
    chk("R9 nop no verdict", {31'd0, verdict_valid}, 32'd0);
    send(P_RD, 0, 1'b0, '0);
    verdict("R9 later legal read", 1'b1, 4'd0);
    chk("R9 sticky held", {31'd0, err_sticky}, 32'd1);
    do_reset();
    @(negedge clk);
    chk("R9 R10 reset clears sticky", {31'd0, err_sticky}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule